// File: doc/BRIEF.md
# Rational Edge-Preserving Filter Core

This block computes one filtered pixel from a 3×3 neighbourhood that an upstream window generator has already assembled. Up to five filtering directions are evaluated side by side. Each direction takes two pixels that sit on opposite sides of the centre, either in space or in the previous and next frames at the same position. From these and the centre it forms a three-tap linear filter, using a coefficient pair drawn from a small bank of coefficient sets. The direction's result is then scaled by an edge-sensing weight that an external lookup supplies. A weight near zero across an edge suppresses smoothing there, while a weight near one on flat areas keeps it.

The weighted terms are summed. The sum is reduced to integer pixel units with rounding and added to a base value, and the total is clamped to the pixel range. A two-bit mode chooses the base. It can be the centre pixel for a standalone filter, an external input so that several units can be chained to add directions or taps, or the unit's own previous result so that a single unit can make several passes over the same mask. The unit accepts one mask every two clock cycles.

Top module: `rational_filter_core`

## Requirements
- R1: While reset is high and after it, until the first mask is accepted, `out_valid` is 0 and `out_pix` is 0.
- R2: With coefficient set k (`coef_sel` = k), each enabled direction d computes LF = (k+1)·A_d + (−(k+2))·C + (k+1)·B_d in signed arithmetic. A_d is `pix_a[8d+7:8d]`, B_d is `pix_b[8d+7:8d]` and C is `pix_c`.
- R3: Each direction contributes floor(LF·W_d / 64), where W_d = `dir_wt[6d+5:6d]` is an unsigned weight in 64ths.
- R4: The contributions are summed to S. The filter adds floor((S+4)/8) to the selected base.
- R5: The result is clamped: anything below 0 gives 0, and anything above 255 gives 255.
- R6: In mode 2'b00, and also in the spare code 2'b11, the base is `pix_c`.
- R7: In mode 2'b10 the base is `cas_in`.
- R8: In mode 2'b01 the base is the last value driven on `out_pix`, which is 0 after reset.
- R9: A direction whose `dir_en[d]` bit is 0 contributes nothing, whatever its pixels and weight.
- R10: An accepted `in_valid` produces exactly one cycle of `out_valid`, with the result on `out_pix`, after the second rising clock edge that follows the acceptance edge's input setup; that is, two edges after the strobe is sampled.
- R11: An `in_valid` in the cycle right after an accepted one is ignored. It produces no output and does not alter the pending result.
- R12: The coefficient set, mode, base inputs, weights and enables are all taken from the cycle in which the mask is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Mask strobe |
| mode | input | 2 | Output base select (00 centre, 01 own previous result, 10 cascade input, 11 centre) |
| coef_sel | input | 2 | Coefficient set index |
| dir_en | input | 5 | Per-direction enable |
| pix_c | input | 8 | Centre pixel |
| pix_a | input | 40 | First pixel of each direction pair, direction d in bits 8d+7:8d |
| pix_b | input | 40 | Opposite pixel of each direction pair |
| dir_wt | input | 30 | Edge weight per direction in 64ths, direction d in bits 6d+5:6d |
| cas_in | input | 8 | Base from a preceding unit in a chain |
| out_valid | output | 1 | Result strobe |
| out_pix | output | 8 | Filtered pixel |

## Verification
The assertions take for granted that `in_valid` and the data that goes with it are steady across a sampling edge, and that reset is held long enough for the stage registers to clear. The pulse-shape and latency checks rely on nothing upstream holding the strobe high across consecutive cycles with the expectation that every cycle is taken. The stimulus drives all inputs at the falling edge, holds a mask for exactly one cycle, and raises the strobe in the following cycle only where the ignored-strobe behaviour is the subject. The hold checks for cascade and iterative modes apply only when the weighted sum is zero, and the stimulus includes fully disabled masks that produce that case.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int PIX_W_D    = 8;
    localparam int COEF_W_D   = 6;
    localparam int WT_W_D     = 6;
    localparam int NDIR_D     = 5;
    localparam int NSETS_D    = 4;
    localparam int SUM_FRAC_D = 3;

    typedef enum logic [1:0] {
        BASE_CENTRE = 2'b00,
        BASE_SELF   = 2'b01,
        BASE_CHAIN  = 2'b10,
        BASE_SPARE  = 2'b11
    } base_mode_e;

    // Outer-tap coefficient of set k: k+1
    function automatic int outer_coef(input int k);
        return k + 1;
    endfunction

    // Centre-tap coefficient of set k: -(k+2)
    function automatic int centre_coef(input int k);
        return -(k + 2);
    endfunction

endpackage

// File: rtl/rf_dir_lane.sv
module rf_dir_lane #(
    parameter int PIX_W  = rf_pkg::PIX_W_D,
    parameter int COEF_W = rf_pkg::COEF_W_D,
    parameter int SEL_W  = 2,
    parameter int LF_W   = PIX_W + COEF_W + 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   en,
    input  logic [SEL_W-1:0]       sel,
    input  logic [PIX_W-1:0]       pa,
    input  logic [PIX_W-1:0]       pb,
    input  logic [PIX_W-1:0]       pc,
    output logic signed [LF_W-1:0] lf_q
);
    logic signed [LF_W-1:0] xa, xb, xc, kb, ka, lf;

    always_comb begin
        xa = LF_W'($signed({1'b0, pa}));
        xb = LF_W'($signed({1'b0, pb}));
        xc = LF_W'($signed({1'b0, pc}));
        kb = LF_W'(rf_pkg::outer_coef(int'(sel)));
        ka = LF_W'(rf_pkg::centre_coef(int'(sel)));
        lf = xa * kb + xc * ka + xb * kb;
    end

    always_ff @(posedge clk) begin
        if (rst)       lf_q <= '0;
        else if (load) lf_q <= en ? lf : '0;
    end

    // R9: a disabled direction holds a zero term
    p_lane_off_r9: assert property (@(posedge clk) disable iff (rst)
        (load && !en) |=> (lf_q == '0));

endmodule

// File: rtl/rf_weight_tree.sv
module rf_weight_tree #(
    parameter int NDIR  = rf_pkg::NDIR_D,
    parameter int LF_W  = 17,
    parameter int WT_W  = rf_pkg::WT_W_D,
    parameter int SUM_W = 22
) (
    input  logic [NDIR*LF_W-1:0]    lf_flat,
    input  logic [NDIR*WT_W-1:0]    wt_flat,
    output logic signed [SUM_W-1:0] sum
);
    localparam int PROD_W = LF_W + WT_W + 1;

    logic signed [SUM_W-1:0] term [NDIR];

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic signed [PROD_W-1:0] el, ew, prod;
        always_comb begin
            el      = PROD_W'($signed(lf_flat[d*LF_W +: LF_W]));
            ew      = PROD_W'($signed({1'b0, wt_flat[d*WT_W +: WT_W]}));
            prod    = el * ew;
            term[d] = SUM_W'(prod >>> WT_W);
        end
    end

    always_comb begin
        sum = '0;
        for (int d = 0; d < NDIR; d++) sum = sum + term[d];
    end

endmodule

// File: rtl/rf_out_stage.sv
module rf_out_stage #(
    parameter int PIX_W = rf_pkg::PIX_W_D,
    parameter int SUM_W = 22,
    parameter int FRAC  = rf_pkg::SUM_FRAC_D
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic [1:0]              mode,
    input  logic [PIX_W-1:0]        centre,
    input  logic [PIX_W-1:0]        chain,
    input  logic signed [SUM_W-1:0] sum,
    output logic                    out_valid,
    output logic [PIX_W-1:0]        out_pix
);
    import rf_pkg::*;

    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(2 ** (FRAC - 1));
    localparam logic signed [SUM_W:0]   PMAX = (SUM_W + 1)'(2 ** PIX_W - 1);

    base_mode_e              bm;
    logic [PIX_W-1:0]        base;
    logic signed [SUM_W-1:0] rnd;
    logic signed [SUM_W:0]   tot;
    logic [PIX_W-1:0]        clamped;

    always_comb begin
        bm = base_mode_e'(mode);
        unique case (bm)
            BASE_SELF:  base = out_pix;
            BASE_CHAIN: base = chain;
            default:    base = centre;
        endcase
        rnd = (sum + HALF) >>> FRAC;
        tot = (SUM_W + 1)'($signed({1'b0, base})) + (SUM_W + 1)'(rnd);
        if (tot < 0)          clamped = '0;
        else if (tot > PMAX)  clamped = '1;
        else                  clamped = tot[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= fire;
            if (fire) out_pix <= clamped;
        end
    end

    // R10: result strobe is a single-cycle pulse following each issue
    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);
    // R8: with no filter contribution the self-fed base is kept
    p_self_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == 2'b01 && sum == '0) |=> (out_pix == $past(out_pix)));
    // R7: with no filter contribution the chain input passes through
    p_chain_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == 2'b10 && sum == '0) |=> (out_pix == $past(chain)));

endmodule

// File: rtl/rational_filter_core.sv
module rational_filter_core #(
    parameter int NDIR     = rf_pkg::NDIR_D,
    parameter int PIX_W    = rf_pkg::PIX_W_D,
    parameter int COEF_W   = rf_pkg::COEF_W_D,
    parameter int WT_W     = rf_pkg::WT_W_D,
    parameter int NSETS    = rf_pkg::NSETS_D,
    parameter int SUM_FRAC = rf_pkg::SUM_FRAC_D,
    localparam int SEL_W   = $clog2(NSETS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            mode,
    input  logic [SEL_W-1:0]      coef_sel,
    input  logic [NDIR-1:0]       dir_en,
    input  logic [PIX_W-1:0]      pix_c,
    input  logic [NDIR*PIX_W-1:0] pix_a,
    input  logic [NDIR*PIX_W-1:0] pix_b,
    input  logic [NDIR*WT_W-1:0]  dir_wt,
    input  logic [PIX_W-1:0]      cas_in,
    output logic                  out_valid,
    output logic [PIX_W-1:0]      out_pix
);
    localparam int LF_W   = PIX_W + COEF_W + 3;
    localparam int SUM_W  = LF_W + 1 + $clog2(NDIR) + 1;

    logic                    s1_valid;
    logic                    accept;
    logic [1:0]              mode_q;
    logic [PIX_W-1:0]        centre_q, chain_q;
    logic [NDIR*WT_W-1:0]    wt_q;
    logic [NDIR*LF_W-1:0]    lf_flat;
    logic signed [SUM_W-1:0] sum;

    assign accept = in_valid && !s1_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            mode_q   <= '0;
            centre_q <= '0;
            chain_q  <= '0;
            wt_q     <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                mode_q   <= mode;
                centre_q <= pix_c;
                chain_q  <= cas_in;
                wt_q     <= dir_wt;
            end
        end
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_lane
        logic signed [LF_W-1:0] lf_d;
        rf_dir_lane #(
            .PIX_W (PIX_W),
            .COEF_W(COEF_W),
            .SEL_W (SEL_W),
            .LF_W  (LF_W)
        ) u_lane (
            .clk (clk),
            .rst (rst),
            .load(accept),
            .en  (dir_en[d]),
            .sel (coef_sel),
            .pa  (pix_a[d*PIX_W +: PIX_W]),
            .pb  (pix_b[d*PIX_W +: PIX_W]),
            .pc  (pix_c),
            .lf_q(lf_d)
        );
        assign lf_flat[d*LF_W +: LF_W] = lf_d;
    end

    rf_weight_tree #(
        .NDIR (NDIR),
        .LF_W (LF_W),
        .WT_W (WT_W),
        .SUM_W(SUM_W)
    ) u_tree (
        .lf_flat(lf_flat),
        .wt_flat(wt_q),
        .sum    (sum)
    );

    rf_out_stage #(
        .PIX_W(PIX_W),
        .SUM_W(SUM_W),
        .FRAC (SUM_FRAC)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .fire     (s1_valid),
        .mode     (mode_q),
        .centre   (centre_q),
        .chain    (chain_q),
        .sum      (sum),
        .out_valid(out_valid),
        .out_pix  (out_pix)
    );

    // R11: no mask is taken in the cycle after one was taken
    p_issue_gap_r11: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> !s1_valid);
    // R1: no result strobe while the first stage is empty after reset
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!s1_valid) |=> !out_valid);

endmodule

// File: tb/test_rational_filter_core.sv
module test_rational_filter_core;

    typedef struct packed {
        logic [39:0] pa;
        logic [39:0] pb;
        logic [7:0]  pc;
        logic [29:0] wt;
        logic [4:0]  en;
        logic [1:0]  mode;
        logic [1:0]  sel;
        logic [7:0]  cas;
    } vec_t;

    // Stimulus table; expected values come from model() below.
    // 0 flat, basic (R6)  1 one edge direction (R2 R3 R4)  2 clamp high (R5)
    // 3 clamp low (R5)    4 chain base (R7)  5 all disabled (R9)
    // 6 self base (R8)    7 mixed, set 2, partial enable (R12 R9)
    // 8 self base, set 3, negative pull (R8 R12)
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{{5{8'd100}}, {5{8'd100}}, 8'd100, {5{6'd63}}, 5'b11111, 2'b00, 2'd0, 8'd0},
        '{{5{8'd200}}, {5{8'd200}}, 8'd100, {5{6'd32}}, 5'b00001, 2'b00, 2'd0, 8'd0},
        '{{5{8'd255}}, {5{8'd255}}, 8'd250, {5{6'd63}}, 5'b11111, 2'b00, 2'd3, 8'd0},
        '{{5{8'd0}},   {5{8'd0}},   8'd10,  {5{6'd63}}, 5'b11111, 2'b00, 2'd1, 8'd0},
        '{{5{8'd200}}, {5{8'd200}}, 8'd100, {5{6'd32}}, 5'b00001, 2'b10, 2'd0, 8'd50},
        '{{5{8'd250}}, {5{8'd3}},   8'd77,  {5{6'd63}}, 5'b00000, 2'b00, 2'd2, 8'd9},
        '{{5{8'd200}}, {5{8'd200}}, 8'd100, {5{6'd32}}, 5'b00001, 2'b01, 2'd0, 8'd200},
        '{{8'd10, 8'd240, 8'd90, 8'd130, 8'd60}, {8'd20, 8'd200, 8'd110, 8'd70, 8'd64},
          8'd100, {6'd5, 6'd63, 6'd40, 6'd17, 6'd0}, 5'b10111, 2'b00, 2'd2, 8'd0},
        '{{5{8'd40}},  {5{8'd30}},  8'd90,  {5{6'd20}}, 5'b01011, 2'b01, 2'd3, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic [1:0]  coef_sel = '0;
    logic [4:0]  dir_en = '0;
    logic [7:0]  pix_c = '0;
    logic [39:0] pix_a = '0;
    logic [39:0] pix_b = '0;
    logic [29:0] dir_wt = '0;
    logic [7:0]  cas_in = '0;
    logic        out_valid;
    logic [7:0]  out_pix;

    int nchk = 0;
    int nerr = 0;
    int exp_prev = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rational_filter_core i_rational_filter_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .coef_sel(coef_sel), .dir_en(dir_en), .pix_c(pix_c),
        .pix_a(pix_a), .pix_b(pix_b), .dir_wt(dir_wt), .cas_in(cas_in),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int model(vec_t v, int prev);
        int acc = 0;
        int kb  = int'(v.sel) + 1;
        int ka  = -(int'(v.sel) + 2);
        int r, base, y;
        for (int d = 0; d < 5; d++) begin
            if (v.en[d]) begin
                int lf;
                lf  = kb * int'(v.pa[d*8 +: 8]) + ka * int'(v.pc) + kb * int'(v.pb[d*8 +: 8]);
                acc = acc + ((lf * int'(v.wt[d*6 +: 6])) >>> 6);
            end
        end
        r = (acc + 4) >>> 3;
        case (v.mode)
            2'b10:   base = int'(v.cas);
            2'b01:   base = prev;
            default: base = int'(v.pc);
        endcase
        y = base + r;
        if (y < 0)   y = 0;
        if (y > 255) y = 255;
        return y;
    endfunction

    task automatic check(string tag, int act, int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic drive(vec_t v, logic vld);
        pix_a = v.pa; pix_b = v.pb; pix_c = v.pc; dir_wt = v.wt;
        dir_en = v.en; mode = v.mode; coef_sel = v.sel; cas_in = v.cas;
        in_valid = vld;
    endtask

    task automatic run_vec(vec_t v, string tag, bit with_extra, vec_t alt);
        int expv;
        int held;
        expv = model(v, exp_prev);
        @(negedge clk) drive(v, 1'b1);
        @(negedge clk);
        if (with_extra) drive(alt, 1'b1);
        else            in_valid = 1'b0;
        @(negedge clk) in_valid = 1'b0;
        check({tag, " R10 out_valid"}, int'(out_valid), 1);
        check({tag, " out_pix"}, int'(out_pix), expv);
        exp_prev = expv;
        held = int'(out_pix);
        @(negedge clk);
        check({tag, " R10/R11 strobe low after pulse"}, int'(out_valid), 0);
        check({tag, " R11 result held"}, int'(out_pix), held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        vec_t alt;
        vec_t v;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset out_pix", int'(out_pix), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle out_valid", int'(out_valid), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], $sformatf("table vec %0d", i), 1'b0, VECS[i]);
        end

        // R11: strobe in the busy cycle carries a different mask; must be dropped
        alt = VECS[2];
        run_vec(VECS[1], "R11 dropped strobe", 1'b1, alt);

        // R6: spare mode code uses the centre pixel as base
        v = VECS[1];
        v.mode = 2'b11;
        run_vec(v, "R6 spare mode", 1'b0, v);

        // R12: coefficient set 3 on the edge mask
        v = VECS[1];
        v.sel = 2'd3;
        run_vec(v, "R12 set 3", 1'b0, v);

        // R8 / R1: reset clears the self-fed base to 0
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mid-run reset out_pix", int'(out_pix), 0);
        rst = 1'b0;
        exp_prev = 0;
        run_vec(VECS[6], "R8 self base from zero", 1'b0, VECS[6]);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule